// File: doc/BRIEF.md
# Shared-Memory Single-Cycle Processor Core

This block is a small 32-bit processor that completes one instruction on every clock edge. Its program and its data sit in one word-addressed store of 2048 words. The lower half holds code and the upper half holds data. On each cycle the core does four things:

- It fetches the word at the program counter.
- It reads two registers from a 32-entry register file.
- It computes a result, a memory address and the next program counter.
- It commits the register write, the store and the new program counter together.

Because code and data share the store, a program can overwrite its own instructions.

A test environment fills the store through a load port while reset is held. It then releases reset and waits for the halt flag. The core raises that flag once the program counter leaves the code half. A combinational peek port reads any word of the store, so results that a program has stored can be inspected after the run.

Top module: `unimem_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears every register and keeps halt low.
- R2: The store holds 2048 words of 32 bits and is addressed by word. Words 0 to 1023 are the code half and words 1024 to 2047 are the data half. The core fetches the word whose address is the low 11 bits of the program counter.
- R3: The instruction fields are:
  - opcode: bits 31:28.
  - first register A: bits 27:23.
  - second register B: bits 22:18.
  - third register C: bits 17:13.
  - shift amount: bits 12:0.
  - immediate: bits 17:0, sign-extended to 32 bits.
  - jump target: bits 27:0.

  The opcode values are 0 add, 1 subtract, 2 multiply-immediate, 3 add-immediate, 4 branch-if-not-equal, 5 and-immediate, 6 or-immediate, 7 jump, 8 shift-left, 9 shift-right, 10 load and 11 store. Opcodes 12 to 15 change nothing except advancing the program counter by one.
- R4: The arithmetic instructions write register A, using B as the first operand:
  - add and subtract: A = B + C and A = B - C.
  - multiply-, add-, and- and or-immediate: B combined with the sign-extended immediate.
  - shift-left and shift-right: B shifted logically by the shift amount. The result is zero when the amount is 32 or more.

  A multiply keeps the low 32 bits of the product.
- R5: Register 0 always reads as zero, and a write that targets it is discarded.
- R6: Branch-if-not-equal sets the program counter to PC+1+immediate when registers A and B differ, and to PC+1 otherwise. Jump sets it to the old top four bits joined to the 28-bit target. Every other instruction sets it to PC+1.
- R7: Load and store use the address B + immediate. A load writes that word into A, and a store writes A into that word. If the address, taken as an unsigned 32-bit value, is 2048 or more, the access is dropped: no word is written and a load leaves A unchanged.
- R8: The register write, the store and the new program counter take effect on the same rising edge, so a program of N instructions takes N cycles. A word stored into the code half is what the next fetch of that address executes.
- R9: Halt is high while the program counter is 1024 or more. While halt is high the program counter holds and no register or store word is written.
- R10: The load port writes a word only while reset is high and has no effect otherwise. The peek port returns the stored word at its address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_we | input | 1 | Load-port write strobe, honoured only during reset |
| load_addr | input | 11 | Load-port word address |
| load_data | input | 32 | Load-port write word |
| peek_addr | input | 11 | Peek-port word address |
| peek_data | output | 32 | Word stored at peek_addr |
| pc | output | 32 | Current program counter |
| halt | output | 1 | High while the program counter is outside the code half |

## Verification
The hardest situation to reach from the ports is a program that rewrites its own next instruction. There is no way to write an instruction word into the code half except from a register, and an immediate cannot build a full 32-bit instruction. The stimulus therefore preloads the wanted instruction into the data half, loads it into a register and stores it over the very next code word. The result then shows whether the fetch after that edge saw the new word.

Addresses that would wrap are a second difficult case. A base of -1 and an offset of 2048 are chosen so that a wrapping design would silently corrupt word 2047 or word 0. The bench then reads both words through the peek port.

// File: rtl/unimem_pkg.sv
package unimem_pkg;

   // Fixed instruction geometry
   localparam int INSN_W    = 32;
   localparam int OPC_W     = 4;
   localparam int REG_IDX_W = 5;
   localparam int IMM_W     = 18;
   localparam int SHAMT_W   = 13;
   localparam int TGT_W     = 28;

   localparam int OPC_LSB   = INSN_W - OPC_W;           // 28
   localparam int RA_LSB    = OPC_LSB - REG_IDX_W;      // 23
   localparam int RB_LSB    = RA_LSB - REG_IDX_W;       // 18
   localparam int RC_LSB    = RB_LSB - REG_IDX_W;       // 13

   // Opcode values (R3)
   localparam logic [OPC_W-1:0] OPC_ADD  = 4'd0;
   localparam logic [OPC_W-1:0] OPC_SUB  = 4'd1;
   localparam logic [OPC_W-1:0] OPC_MULI = 4'd2;
   localparam logic [OPC_W-1:0] OPC_ADDI = 4'd3;
   localparam logic [OPC_W-1:0] OPC_BNE  = 4'd4;
   localparam logic [OPC_W-1:0] OPC_ANDI = 4'd5;
   localparam logic [OPC_W-1:0] OPC_ORI  = 4'd6;
   localparam logic [OPC_W-1:0] OPC_JMP  = 4'd7;
   localparam logic [OPC_W-1:0] OPC_SLL  = 4'd8;
   localparam logic [OPC_W-1:0] OPC_SRL  = 4'd9;
   localparam logic [OPC_W-1:0] OPC_LW   = 4'd10;
   localparam logic [OPC_W-1:0] OPC_SW   = 4'd11;

   typedef struct packed {
      logic [OPC_W-1:0]     opc;
      logic [REG_IDX_W-1:0] ra;
      logic [REG_IDX_W-1:0] rb;
      logic [REG_IDX_W-1:0] rc;
      logic [SHAMT_W-1:0]   shamt;
      logic [INSN_W-1:0]    imm;
      logic [TGT_W-1:0]     target;
      logic                 wr_reg;
      logic                 is_load;
      logic                 is_store;
   } dec_t;

endpackage

// File: rtl/unimem_decode.sv
module unimem_decode
   import unimem_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output dec_t              dec
);

   always_comb begin
      dec          = '0;
      dec.opc      = insn[INSN_W-1:OPC_LSB];
      dec.ra       = insn[OPC_LSB-1:RA_LSB];
      dec.rb       = insn[RA_LSB-1:RB_LSB];
      dec.rc       = insn[RB_LSB-1:RC_LSB];
      dec.shamt    = insn[SHAMT_W-1:0];
      dec.imm      = {{(INSN_W-IMM_W){insn[IMM_W-1]}}, insn[IMM_W-1:0]};
      dec.target   = insn[TGT_W-1:0];
      case (insn[INSN_W-1:OPC_LSB])
         OPC_ADD, OPC_SUB, OPC_MULI, OPC_ADDI,
         OPC_ANDI, OPC_ORI, OPC_SLL, OPC_SRL: dec.wr_reg = 1'b1;
         OPC_LW: begin
            dec.wr_reg  = 1'b1;
            dec.is_load = 1'b1;
         end
         OPC_SW:  dec.is_store = 1'b1;
         default: ;  // branch, jump, and spare opcodes write nothing (R3)
      endcase
   end

endmodule

// File: rtl/unimem_regfile.sv
module unimem_regfile #(
   parameter  int DATA_W = 32,
   parameter  int NREG   = 32,
   localparam int IW     = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IW-1:0]     raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [IW-1:0]     raddr_b,
   output logic [DATA_W-1:0] rdata_b
);

   logic [DATA_W-1:0] view [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_cell
      if (i == 0) begin : g_zero
         // R5: index zero has no storage and reads as zero
         assign view[i] = '0;
      end else begin : g_live
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) begin
               q <= '0;                       // R1
            end else if (we && (waddr == IW'(i))) begin
               q <= wdata;
            end
         end
         assign view[i] = q;
      end
   end

   assign rdata_a = view[raddr_a];
   assign rdata_b = view[raddr_b];

endmodule

// File: rtl/unimem_exec.sv
module unimem_exec
   import unimem_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AW     = 11
) (
   input  logic [OPC_W-1:0]   opc,
   input  logic [DATA_W-1:0]  imm,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [TGT_W-1:0]   target,
   input  logic [DATA_W-1:0]  va,       // value of register B
   input  logic [DATA_W-1:0]  vx,       // value of register C or A
   input  logic [DATA_W-1:0]  pc,
   output logic [DATA_W-1:0]  result,
   output logic [DATA_W-1:0]  next_pc,
   output logic [AW-1:0]      ea_lo,
   output logic               ea_ok
);

   logic [DATA_W-1:0] ea_full;
   logic [DATA_W-1:0] pc_inc;

   // R4: arithmetic and logic
   always_comb begin
      case (opc)
         OPC_ADD:  result = va + vx;
         OPC_SUB:  result = va - vx;
         OPC_MULI: result = va * imm;
         OPC_ADDI: result = va + imm;
         OPC_ANDI: result = va & imm;
         OPC_ORI:  result = va | imm;
         OPC_SLL:  result = va << shamt;
         OPC_SRL:  result = va >> shamt;
         default:  result = '0;
      endcase
   end

   // R7: effective address and range check (no wrap)
   assign ea_full = va + imm;
   assign ea_lo   = ea_full[AW-1:0];
   assign ea_ok   = ((ea_full >> AW) == '0);

   // R6: next program counter
   assign pc_inc = pc + DATA_W'(1);
   always_comb begin
      if ((opc == OPC_BNE) && (va != vx)) begin
         next_pc = pc_inc + imm;
      end else if (opc == OPC_JMP) begin
         next_pc = {pc[DATA_W-1:TGT_W], target};
      end else begin
         next_pc = pc_inc;
      end
   end

endmodule

// File: rtl/unimem_store.sv
module unimem_store #(
   parameter  int DATA_W = 32,
   parameter  int DEPTH  = 2048,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     fetch_addr,
   output logic [DATA_W-1:0] fetch_data,
   input  logic [AW-1:0]     ld_addr,
   output logic [DATA_W-1:0] ld_data,
   input  logic [AW-1:0]     peek_addr,
   output logic [DATA_W-1:0] peek_data
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   // Asynchronous reads keep fetch, load and peek inside one cycle (R8, R10)
   assign fetch_data = cells[fetch_addr];
   assign ld_data    = cells[ld_addr];
   assign peek_data  = cells[peek_addr];

endmodule

// File: rtl/unimem_cpu.sv
module unimem_cpu
   import unimem_pkg::*;
#(
   parameter  int DATA_W     = 32,
   parameter  int MEM_DEPTH  = 2048,
   parameter  int PROG_DEPTH = 1024,
   parameter  int NREG       = 32,
   localparam int AW         = $clog2(MEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_we,
   input  logic [AW-1:0]     load_addr,
   input  logic [DATA_W-1:0] load_data,
   input  logic [AW-1:0]     peek_addr,
   output logic [DATA_W-1:0] peek_data,
   output logic [DATA_W-1:0] pc,
   output logic              halt
);

   // Elaboration-time parameter checks
   if (DATA_W != INSN_W) begin : g_bad_width
      $error("unimem_cpu: DATA_W must equal the 32-bit instruction width");
   end
   if ((1 << AW) != MEM_DEPTH) begin : g_bad_depth
      $error("unimem_cpu: MEM_DEPTH must be a power of two");
   end
   if (PROG_DEPTH >= MEM_DEPTH || PROG_DEPTH < 1) begin : g_bad_prog
      $error("unimem_cpu: PROG_DEPTH must lie inside the store");
   end
   if (NREG != (1 << REG_IDX_W)) begin : g_bad_nreg
      $error("unimem_cpu: NREG must match the register index field");
   end

   logic [DATA_W-1:0]    pc_q;
   logic                 active;
   logic [DATA_W-1:0]    insn;
   dec_t                 dec;
   logic [OPC_W-1:0]     cur_opc;
   logic [REG_IDX_W-1:0] src_x_idx;
   logic [DATA_W-1:0]    val_b;
   logic [DATA_W-1:0]    val_x;
   logic [DATA_W-1:0]    alu_res;
   logic [DATA_W-1:0]    npc;
   logic [AW-1:0]        ea_lo;
   logic                 ea_ok;
   logic [DATA_W-1:0]    ld_word;
   logic                 mem_we;
   logic [AW-1:0]        mem_waddr;
   logic [DATA_W-1:0]    mem_wdata;
   logic                 rf_we;
   logic [DATA_W-1:0]    rf_wdata;

   // R9: halt while outside the code half
   assign halt   = (pc_q >= DATA_W'(PROG_DEPTH));
   assign active = !halt;
   assign pc     = pc_q;

   unimem_store #(
      .DATA_W (DATA_W),
      .DEPTH  (MEM_DEPTH)
   ) u_store (
      .clk        (clk),
      .we         (mem_we),
      .waddr      (mem_waddr),
      .wdata      (mem_wdata),
      .fetch_addr (pc_q[AW-1:0]),
      .fetch_data (insn),
      .ld_addr    (ea_lo),
      .ld_data    (ld_word),
      .peek_addr  (peek_addr),
      .peek_data  (peek_data)
   );

   unimem_decode u_dec (
      .insn (insn),
      .dec  (dec)
   );

   assign cur_opc = dec.opc;

   // Second read port: C for register-register arithmetic, A otherwise
   assign src_x_idx = ((dec.opc == OPC_ADD) || (dec.opc == OPC_SUB)) ? dec.rc : dec.ra;

   unimem_regfile #(
      .DATA_W (DATA_W),
      .NREG   (NREG)
   ) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (rf_we),
      .waddr   (dec.ra),
      .wdata   (rf_wdata),
      .raddr_a (dec.rb),
      .rdata_a (val_b),
      .raddr_b (src_x_idx),
      .rdata_b (val_x)
   );

   unimem_exec #(
      .DATA_W (DATA_W),
      .AW     (AW)
   ) u_exec (
      .opc     (dec.opc),
      .imm     (dec.imm),
      .shamt   (dec.shamt),
      .target  (dec.target),
      .va      (val_b),
      .vx      (val_x),
      .pc      (pc_q),
      .result  (alu_res),
      .next_pc (npc),
      .ea_lo   (ea_lo),
      .ea_ok   (ea_ok)
   );

   // R7, R9: register write-back, dropped for out-of-range loads and when halted
   assign rf_we    = !rst && active && dec.wr_reg && (!dec.is_load || ea_ok);
   assign rf_wdata = dec.is_load ? ld_word : alu_res;

   // R10: the load port owns the write port only during reset
   always_comb begin
      if (rst) begin
         mem_we    = load_we;
         mem_waddr = load_addr;
         mem_wdata = load_data;
      end else begin
         mem_we    = active && dec.is_store && ea_ok;
         mem_waddr = ea_lo;
         mem_wdata = val_x;
      end
   end

   // R1, R8, R9: program counter
   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
      end else if (active) begin
         pc_q <= npc;
      end
   end

endmodule

// File: rtl/unimem_cpu_chk.sv
module unimem_cpu_chk #(
   parameter int DATA_W = 32,
   parameter int IW     = 5
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] pc,
   input logic              halt,
   input logic [3:0]        opc,
   input logic [IW-1:0]     src_idx,
   input logic [DATA_W-1:0] src_val,
   input logic              mem_we
);

   assert_reset_pc_R1: assert property (@(posedge clk)
      rst |=> (pc == '0))
      else $error("reset did not clear the program counter");

   assert_zero_reads_R5: assert property (@(posedge clk) disable iff (rst)
      (src_idx == '0) |-> (src_val == '0))
      else $error("register zero read non-zero");

   assert_seq_pc_R6: assert property (@(posedge clk) disable iff (rst)
      (!halt && (opc != 4'd4) && (opc != 4'd7)) |=> (pc == $past(pc) + DATA_W'(1)))
      else $error("program counter did not advance by one");

   assert_store_only_R7: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (opc == 4'd11))
      else $error("store write without a store instruction");

   assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (rst)
      halt |=> (halt && $stable(pc)))
      else $error("program counter moved while halted");

   assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      halt |-> !mem_we)
      else $error("store written while halted");

endmodule

bind unimem_cpu unimem_cpu_chk #(
   .DATA_W (DATA_W),
   .IW     (5)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .pc      (pc),
   .halt    (halt),
   .opc     (cur_opc),
   .src_idx (dec.rb),
   .src_val (val_b),
   .mem_we  (mem_we)
);

// File: tb/sim_unimem_cpu.sv
module sim_unimem_cpu;

   localparam int DW    = 32;
   localparam int DEPTH = 2048;
   localparam int PROG  = 1024;
   localparam int AW    = 11;

   localparam int OP_ADD = 0, OP_SUB = 1, OP_MULI = 2, OP_ADDI = 3, OP_BNE = 4,
                  OP_ANDI = 5, OP_ORI = 6, OP_JMP = 7, OP_SLL = 8, OP_SRL = 9,
                  OP_LW = 10, OP_SW = 11;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          load_we = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [DW-1:0] load_data = '0;
   logic [AW-1:0] peek_addr = '0;
   logic [DW-1:0] peek_data;
   logic [DW-1:0] pc;
   logic          halt;

   unimem_cpu u0 (
      .clk       (clk),
      .rst       (rst),
      .load_we   (load_we),
      .load_addr (load_addr),
      .load_data (load_data),
      .peek_addr (peek_addr),
      .peek_data (peek_data),
      .pc        (pc),
      .halt      (halt)
   );

   always #10 clk = ~clk;  // 50 MHz

   int n_chk = 0;
   int n_err = 0;
   int cyc_total = 0;
   int wp = 0;

   logic [31:0] img    [DEPTH];
   logic [31:0] rm_mem [DEPTH];
   logic [31:0] rm_reg [32];
   logic [31:0] rm_pc;

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 190000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   function automatic logic [31:0] enc_r(int op, int ra, int rb, int rc, int sh);
      return {4'(op), 5'(ra), 5'(rb), 5'(rc), 13'(sh)};
   endfunction

   function automatic logic [31:0] enc_i(int op, int ra, int rb, int imm);
      return {4'(op), 5'(ra), 5'(rb), 18'(imm)};
   endfunction

   function automatic logic [31:0] enc_j(int tgt);
      return {4'(OP_JMP), 28'(tgt)};
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_img();
      for (int a = 0; a < DEPTH; a++) img[a] = '0;
      wp = 0;
   endtask

   task automatic emit(logic [31:0] w);
      img[wp] = w;
      wp++;
   endtask

   task automatic peek(int a, output logic [31:0] v);
      peek_addr = AW'(a);
      #1;
      v = peek_data;
   endtask

   // Reference model written from the requirements
   task automatic ref_run(output int steps);
      logic [31:0] ins, a, b, c, imm, ea, val, npc;
      int op, ra, rb, rc, sh;
      bit wr;
      for (int i = 0; i < DEPTH; i++) rm_mem[i] = img[i];
      for (int i = 0; i < 32; i++) rm_reg[i] = '0;
      rm_pc = '0;
      steps = 0;
      while (rm_pc < PROG && steps < 5000) begin
         ins = rm_mem[rm_pc[10:0]];
         op  = int'(ins[31:28]);
         ra  = int'(ins[27:23]);
         rb  = int'(ins[22:18]);
         rc  = int'(ins[17:13]);
         sh  = int'(ins[12:0]);
         imm = {{14{ins[17]}}, ins[17:0]};
         a = rm_reg[ra];
         b = rm_reg[rb];
         c = rm_reg[rc];
         ea = b + imm;
         npc = rm_pc + 1;
         wr = 1'b0;
         val = '0;
         case (op)
            OP_ADD:  begin val = b + c; wr = 1'b1; end
            OP_SUB:  begin val = b - c; wr = 1'b1; end
            OP_MULI: begin val = b * imm; wr = 1'b1; end
            OP_ADDI: begin val = b + imm; wr = 1'b1; end
            OP_BNE:  if (a != b) npc = rm_pc + 1 + imm;
            OP_ANDI: begin val = b & imm; wr = 1'b1; end
            OP_ORI:  begin val = b | imm; wr = 1'b1; end
            OP_JMP:  npc = {rm_pc[31:28], ins[27:0]};
            OP_SLL:  begin val = (sh >= 32) ? 32'd0 : (b << sh); wr = 1'b1; end
            OP_SRL:  begin val = (sh >= 32) ? 32'd0 : (b >> sh); wr = 1'b1; end
            OP_LW:   if (ea < DEPTH) begin val = rm_mem[ea[10:0]]; wr = 1'b1; end
            OP_SW:   if (ea < DEPTH) rm_mem[ea[10:0]] = a;
            default: ;
         endcase
         if (wr && ra != 0) rm_reg[ra] = val;
         rm_pc = npc;
         steps++;
      end
   endtask

   task automatic run_prog(string req);
      int steps, cyc, bad, bada;
      logic [31:0] v, badv, bade;
      ref_run(steps);
      @(negedge clk);
      rst = 1'b1;
      load_we = 1'b1;
      for (int a = 0; a < DEPTH; a++) begin
         load_addr = AW'(a);
         load_data = img[a];
         @(negedge clk);
      end
      load_we = 1'b0;
      chk("R1", "pc during reset", pc, 32'd0);
      chk("R1", "halt during reset", {31'd0, halt}, 32'd0);
      rst = 1'b0;
      cyc = 0;
      while (!halt && cyc < 4000) begin
         @(negedge clk);
         cyc++;
      end
      chk("R9", {req, " halt reached"}, {31'd0, halt}, 32'd1);
      chk("R8", {req, " cycles to halt"}, 32'(cyc), 32'(steps));
      chk("R6", {req, " final pc"}, pc, rm_pc);
      bad = 0; bada = 0; badv = '0; bade = '0;
      for (int a = 0; a < DEPTH; a++) begin
         peek(a, v);
         if (v !== rm_mem[a]) begin
            if (bad == 0) begin
               bada = a; badv = v; bade = rm_mem[a];
            end
            bad++;
         end
      end
      chk("R2", $sformatf("%s memory word %0d", req, bada), badv, bade);
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] exp_alu [9];
      void'($urandom(32'd7331));

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "pc after reset", pc, 32'd0);
      chk("R1", "halt after reset", {31'd0, halt}, 32'd0);

      // R4: directed arithmetic corner cases
      clear_img();
      emit(enc_i(OP_ADDI, 1, 0, -3));
      emit(enc_r(OP_SLL, 2, 1, 0, 4));
      emit(enc_r(OP_SRL, 3, 1, 0, 28));
      emit(enc_r(OP_SRL, 4, 1, 0, 40));
      emit(enc_i(OP_MULI, 5, 1, -7));
      emit(enc_i(OP_ANDI, 6, 1, 32'h0FF0));
      emit(enc_i(OP_ORI, 7, 0, -2));
      emit(enc_r(OP_SUB, 8, 0, 1, 0));
      emit(enc_r(OP_ADD, 9, 1, 8, 0));
      emit(enc_r(OP_SLL, 10, 1, 0, 0));
      for (int r = 2; r <= 10; r++) emit(enc_i(OP_SW, r, 0, 1024 + r - 2));
      emit(enc_j(1024));
      run_prog("R4 alu");
      exp_alu = '{32'hFFFFFFD0, 32'h0000000F, 32'h0, 32'd21, 32'h00000FF0,
                  32'hFFFFFFFE, 32'd3, 32'd0, 32'hFFFFFFFD};
      for (int i = 0; i < 9; i++) begin
         peek(1024 + i, v);
         chk("R4", $sformatf("alu result %0d", i), v, exp_alu[i]);
      end

      // R5, R3, R6: register zero, spare opcode, forward jump
      clear_img();
      emit(enc_i(OP_ADDI, 0, 0, 5));
      emit(enc_i(OP_SW, 0, 0, 1024));
      emit(enc_i(OP_ADDI, 2, 0, 7));
      emit(enc_j(5));
      emit(enc_i(OP_ADDI, 2, 0, 99));
      emit(enc_i(OP_SW, 2, 0, 1025));
      emit(enc_i(OP_ADDI, 3, 0, 11));
      emit(enc_r(13, 3, 2, 2, 0));
      emit(enc_i(OP_SW, 3, 0, 1026));
      emit(enc_j(1024));
      run_prog("R5 zero");
      peek(1024, v); chk("R5", "register zero after write", v, 32'd0);
      peek(1025, v); chk("R6", "jump skipped instruction", v, 32'd7);
      peek(1026, v); chk("R3", "spare opcode left register", v, 32'd11);

      // R6: backward branch loop
      clear_img();
      emit(enc_i(OP_ADDI, 1, 0, 0));
      emit(enc_i(OP_ADDI, 2, 0, 5));
      emit(enc_i(OP_ADDI, 1, 1, 1));
      emit(enc_i(OP_BNE, 1, 2, -2));
      emit(enc_i(OP_SW, 1, 0, 1024));
      emit(enc_j(1024));
      run_prog("R6 loop");
      peek(1024, v); chk("R6", "loop count", v, 32'd5);

      // R7: loads, stores and dropped out-of-range accesses
      clear_img();
      img[1030] = 32'hCAFEF00D;
      emit(enc_i(OP_LW, 4, 0, 1030));
      emit(enc_i(OP_SW, 4, 0, 1031));
      emit(enc_i(OP_ADDI, 5, 0, 9));
      emit(enc_i(OP_LW, 5, 0, 2048));
      emit(enc_i(OP_SW, 5, 0, 1032));
      emit(enc_i(OP_ADDI, 6, 0, 66));
      emit(enc_i(OP_SW, 6, 0, 2048));
      emit(enc_i(OP_ADDI, 7, 0, -1));
      emit(enc_i(OP_SW, 6, 7, 0));
      emit(enc_i(OP_SW, 6, 7, 1034));
      emit(enc_j(1024));
      run_prog("R7 mem");
      peek(1031, v); chk("R7", "load then store", v, 32'hCAFEF00D);
      peek(1032, v); chk("R7", "out-of-range load kept register", v, 32'd9);
      peek(0, v);    chk("R7", "store at 2048 did not wrap", v, enc_i(OP_LW, 4, 0, 1030));
      peek(2047, v); chk("R7", "store at -1 did not wrap", v, 32'd0);
      peek(1033, v); chk("R7", "negative base plus offset", v, 32'd66);

      // R8: store over the very next instruction
      clear_img();
      img[1500] = enc_i(OP_ADDI, 7, 0, 77);
      emit(enc_i(OP_ADDI, 7, 0, 1));
      emit(enc_i(OP_LW, 3, 0, 1500));
      emit(enc_i(OP_SW, 3, 0, 3));
      emit(enc_i(OP_ADDI, 7, 7, 5));
      emit(enc_i(OP_SW, 7, 0, 1024));
      emit(enc_j(1024));
      run_prog("R8 selfmod");
      peek(1024, v); chk("R8", "rewritten instruction executed", v, 32'd77);

      // R1: registers cleared between runs
      clear_img();
      emit(enc_i(OP_ADDI, 9, 0, 123));
      emit(enc_i(OP_SW, 9, 0, 1024));
      emit(enc_j(1024));
      run_prog("R1 setup");
      peek(1024, v); chk("R4", "setup value", v, 32'd123);
      clear_img();
      emit(enc_i(OP_SW, 9, 0, 1025));
      emit(enc_j(1024));
      run_prog("R1 clear");
      peek(1025, v); chk("R1", "register cleared by reset", v, 32'd0);

      // R9: fall through into the data half and stay halted
      clear_img();
      img[0] = enc_i(OP_ADDI, 1, 0, 3);
      img[1024] = enc_i(OP_SW, 1, 0, 1100);
      run_prog("R9 fall");
      repeat (5) @(negedge clk);
      chk("R9", "pc frozen", pc, 32'd1024);
      chk("R9", "halt held", {31'd0, halt}, 32'd1);
      peek(1100, v); chk("R9", "data word not executed", v, 32'd0);

      // R10: load port ignored outside reset
      @(negedge clk);
      load_we = 1'b1;
      load_addr = AW'(1200);
      load_data = 32'h12345678;
      repeat (3) @(negedge clk);
      load_we = 1'b0;
      peek(1200, v); chk("R10", "load port outside reset", v, 32'd0);

      // R4, R7: random programs against the reference model
      for (int run = 0; run < 6; run++) begin
         clear_img();
         for (int a = 1024; a < 1124; a++) img[a] = $urandom();
         for (int k = 0; k < 40; k++) begin
            int pick, ra, rb, rc, imm;
            pick = int'($urandom_range(0, 9));
            ra = int'($urandom_range(0, 31));
            rb = int'($urandom_range(0, 31));
            rc = int'($urandom_range(0, 31));
            imm = int'($urandom_range(0, 262143));
            case (pick)
               0: emit(enc_r(OP_ADD, ra, rb, rc, 0));
               1: emit(enc_r(OP_SUB, ra, rb, rc, 0));
               2: emit(enc_i(OP_MULI, ra, rb, imm));
               3: emit(enc_i(OP_ADDI, ra, rb, imm));
               4: emit(enc_i(OP_LW, ra, 0, int'($urandom_range(1024, 1123))));
               5: emit(enc_i(OP_ANDI, ra, rb, imm));
               6: emit(enc_i(OP_ORI, ra, rb, imm));
               7: emit(enc_i(OP_SW, ra, 0, int'($urandom_range(1124, 1200))));
               8: emit(enc_r(OP_SLL, ra, rb, 0, int'($urandom_range(0, 40))));
               default: emit(enc_r(OP_SRL, ra, rb, 0, int'($urandom_range(0, 40))));
            endcase
         end
         for (int r = 1; r < 32; r++) emit(enc_i(OP_SW, r, 0, 1300 + r));
         emit(enc_j(1024));
         run_prog($sformatf("R4 random %0d", run));
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule